// File: doc/BRIEF.md
# Pipeline Converter Self-Test Sequencer

This controller runs the built-in self-test of a pipelined analog-to-digital converter and reduces it to one go/no-go result. It does not touch analog signals. Each analog test circuit sits behind a request/response handshake, and the sequencer drives those handshakes in a fixed order.

The order is as follows. First it checks the whole converter for monotonic output. It then checks the DC gain of each stage, one stage at a time. Next it calibrates the analog timer and waits for that timer to report ready. Last, it measures the delay of each stage, one at a time. While a stage's delay is measured, that stage is switched into its high-gain test mode (x20 instead of the normal x2). A per-wait timeout converts a silent test circuit into a failure. The sequence stops at the first failure and reports which phase and which stage failed. Background gain calibration is enabled whenever the per-stage gain checks are not running.

States: `ST_IDLE`, `ST_MONO`, `ST_GAIN`, `ST_GAIN_NX`, `ST_TCAL`, `ST_DLY`, `ST_DLY_NX`, `ST_FIN`.

Transitions:
- idle→mono on start.
- mono→gain on a passing response.
- gain→gain_nx on a passing stage that is not the last; gain_nx→gain always.
- gain→tcal on a passing last stage.
- tcal→dly on timer ready.
- dly→dly_nx on a passing stage that is not the last; dly_nx→dly always.
- dly→fin on a passing last stage.
- Any waiting state→fin on a failing response or a timeout.
- fin→idle always.

Top module: `adc_bist_seq`

## Requirements
- R1: After reset all requests, `done`, `go`, `hi_gain` and `stage_sel` are 0, `fail_phase` is 0 and `gcal_en` is 1. A `start` pulse seen in idle raises `mono_req` in the next cycle. A `start` seen while `busy` is ignored.
- R2: Gain checks request stages in ascending order 0..NST-1, one request per stage. During a request `stage_sel` is one-hot with bit i set for stage i, and it does not change while the request is high.
- R3: `gcal_en` is 0 for the whole per-stage gain phase and 1 outside it.
- R4: `cal_req` is raised only after every gain check has passed. `dly_req` is raised only after `cal_ready` has been seen in the current run.
- R5: Delay checks scan the stages in ascending order with one-hot `stage_sel`. `hi_gain` is 1 exactly while `dly_req` is 1.
- R6: The first failing response ends the run. `fail_phase` then reads 1 for monotonicity, 2 for gain, 3 for timer calibration and 4 for delay. `fail_stage` holds the failing stage index, or 0 for phases 1 and 3.
- R7: If a waiting phase gets no response, it fails on its (`timeout_limit`+1)-th cycle. Its request is therefore high for exactly `timeout_limit`+1 cycles.
- R8: `done` is high for exactly one cycle at the end of every run. `go` is 1 only if every check passed. The results hold until the next accepted start, which clears them.
- R9: At most one of `mono_req`, `gain_req`, `cal_req` and `dly_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test run (accepted in idle only) |
| timeout_limit | input | TW | Per-wait timeout, in cycles minus one |
| mono_req | output | 1 | Monotonicity check request |
| mono_done | input | 1 | Monotonicity check finished |
| mono_pass | input | 1 | Monotonicity result, valid with done |
| gain_req | output | 1 | Stage gain check request |
| gain_done | input | 1 | Gain check finished |
| gain_pass | input | 1 | Gain result, valid with done |
| cal_req | output | 1 | Analog timer calibration request |
| cal_ready | input | 1 | Timer calibrated |
| dly_req | output | 1 | Stage delay measurement request |
| dly_done | input | 1 | Delay measurement finished |
| dly_pass | input | 1 | Delay result, valid with done |
| stage_sel | output | NST | One-hot stage under test |
| hi_gain | output | 1 | Selected stage in x20 test gain |
| gcal_en | output | 1 | Background gain calibration allowed |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| go | output | 1 | Whole test passed |
| fail_phase | output | 3 | Code of the failing phase, 0 if none |
| fail_stage | output | SW | Index of the failing stage |

## Verification
The stimulus table holds several patterns:
- a clean pass;
- a failing response in each phase, at the first, a middle and the last stage;
- a silent calibration and a silent delay stage, which separate the timeout path from the explicit-fail path;
- a start pulse injected mid-run, which tells an ignored restart apart from a sequence that restarts.

For every pattern the bench counts request edges per phase and the order of stage indices. Those counts reveal whether the scan stops at the right place and whether delay requests wait for the timer. A short timeout with a silent first phase pins the exact expiry cycle.

// File: rtl/adc_bist_pkg.sv
package adc_bist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MONO,
        ST_GAIN,
        ST_GAIN_NX,
        ST_TCAL,
        ST_DLY,
        ST_DLY_NX,
        ST_FIN
    } bist_state_e;

    typedef enum logic [2:0] {
        PH_NONE = 3'd0,
        PH_MONO = 3'd1,
        PH_GAIN = 3'd2,
        PH_TCAL = 3'd3,
        PH_DLY  = 3'd4
    } phase_code_e;

endpackage

// File: rtl/bist_phase_timer.sv
module bist_phase_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = en && (cnt_q == limit);

endmodule

// File: rtl/bist_stage_ptr.sv
module bist_stage_ptr #(
    parameter int NST = 4,
    localparam int SW = (NST > 1) ? $clog2(NST) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           adv,
    output logic [SW-1:0]  idx,
    output logic [NST-1:0] sel,
    output logic           last
);
    localparam logic [SW-1:0] LAST_IDX = SW'(NST - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clr) begin
            idx <= '0;
        end else if (adv && (idx != LAST_IDX)) begin
            idx <= idx + 1'b1;
        end
    end

    for (genvar g = 0; g < NST; g++) begin : g_sel
        assign sel[g] = (idx == SW'(g));
    end

    assign last = (idx == LAST_IDX);

endmodule

// File: rtl/adc_bist_seq.sv
module adc_bist_seq
    import adc_bist_pkg::*;
#(
    parameter int NST = 4,
    parameter int TW  = 8,
    localparam int SW = (NST > 1) ? $clog2(NST) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [TW-1:0]  timeout_limit,
    output logic           mono_req,
    input  logic           mono_done,
    input  logic           mono_pass,
    output logic           gain_req,
    input  logic           gain_done,
    input  logic           gain_pass,
    output logic           cal_req,
    input  logic           cal_ready,
    output logic           dly_req,
    input  logic           dly_done,
    input  logic           dly_pass,
    output logic [NST-1:0] stage_sel,
    output logic           hi_gain,
    output logic           gcal_en,
    output logic           busy,
    output logic           done,
    output logic           go,
    output logic [2:0]     fail_phase,
    output logic [SW-1:0]  fail_stage
);
    bist_state_e   state_q, state_d;
    logic          waiting;
    logic          expired;
    logic          ptr_clr, ptr_adv;
    logic [SW-1:0] idx;
    logic [NST-1:0] sel;
    logic          last;
    logic          rec_fail, rec_pass, rec_clear;
    phase_code_e   rec_code;

    assign waiting = (state_q == ST_MONO) || (state_q == ST_GAIN) ||
                     (state_q == ST_TCAL) || (state_q == ST_DLY);

    bist_phase_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_d != state_q),
        .en      (waiting),
        .limit   (timeout_limit),
        .expired (expired)
    );

    bist_stage_ptr #(.NST(NST)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ptr_clr),
        .adv   (ptr_adv),
        .idx   (idx),
        .sel   (sel),
        .last  (last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and sequencing controls
    always_comb begin
        state_d   = state_q;
        ptr_clr   = 1'b0;
        ptr_adv   = 1'b0;
        rec_fail  = 1'b0;
        rec_pass  = 1'b0;
        rec_clear = 1'b0;
        rec_code  = PH_NONE;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d   = ST_MONO;
                    ptr_clr   = 1'b1;
                    rec_clear = 1'b1;
                end
            end
            ST_MONO: begin
                if (mono_done && mono_pass) begin
                    state_d = ST_GAIN;
                    ptr_clr = 1'b1;
                end else if (mono_done || expired) begin
                    state_d  = ST_FIN;
                    rec_fail = 1'b1;
                    rec_code = PH_MONO;
                end
            end
            ST_GAIN: begin
                if (gain_done && gain_pass) begin
                    if (last) begin
                        state_d = ST_TCAL;
                    end else begin
                        state_d = ST_GAIN_NX;
                        ptr_adv = 1'b1;
                    end
                end else if (gain_done || expired) begin
                    state_d  = ST_FIN;
                    rec_fail = 1'b1;
                    rec_code = PH_GAIN;
                end
            end
            ST_GAIN_NX: begin
                state_d = ST_GAIN;
            end
            ST_TCAL: begin
                if (cal_ready) begin
                    state_d = ST_DLY;
                    ptr_clr = 1'b1;
                end else if (expired) begin
                    state_d  = ST_FIN;
                    rec_fail = 1'b1;
                    rec_code = PH_TCAL;
                end
            end
            ST_DLY: begin
                if (dly_done && dly_pass) begin
                    if (last) begin
                        state_d  = ST_FIN;
                        rec_pass = 1'b1;
                    end else begin
                        state_d = ST_DLY_NX;
                        ptr_adv = 1'b1;
                    end
                end else if (dly_done || expired) begin
                    state_d  = ST_FIN;
                    rec_fail = 1'b1;
                    rec_code = PH_DLY;
                end
            end
            ST_DLY_NX: begin
                state_d = ST_DLY;
            end
            ST_FIN: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs decoded from state
    always_comb begin
        mono_req  = 1'b0;
        gain_req  = 1'b0;
        cal_req   = 1'b0;
        dly_req   = 1'b0;
        hi_gain   = 1'b0;
        stage_sel = '0;
        gcal_en   = 1'b1;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:    busy = 1'b0;
            ST_MONO:    mono_req = 1'b1;
            ST_GAIN: begin
                gain_req  = 1'b1;
                stage_sel = sel;
                gcal_en   = 1'b0;
            end
            ST_GAIN_NX: begin
                stage_sel = sel;
                gcal_en   = 1'b0;
            end
            ST_TCAL:    cal_req = 1'b1;
            ST_DLY: begin
                dly_req   = 1'b1;
                hi_gain   = 1'b1;
                stage_sel = sel;
            end
            ST_DLY_NX:  stage_sel = sel;
            ST_FIN:     done = 1'b1;
            default:    busy = 1'b1;
        endcase
    end

    // sticky results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go         <= 1'b0;
            fail_phase <= PH_NONE;
            fail_stage <= '0;
        end else if (rec_clear) begin
            go         <= 1'b0;
            fail_phase <= PH_NONE;
            fail_stage <= '0;
        end else if (rec_fail) begin
            fail_phase <= rec_code;
            fail_stage <= ((rec_code == PH_GAIN) || (rec_code == PH_DLY)) ? idx : '0;
        end else if (rec_pass) begin
            go <= 1'b1;
        end
    end

endmodule

// File: rtl/adc_bist_seq_chk.sv
module adc_bist_seq_chk #(
    parameter int NST = 4,
    localparam int SW = (NST > 1) ? $clog2(NST) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mono_req,
    input logic           gain_req,
    input logic           cal_req,
    input logic           cal_ready,
    input logic           dly_req,
    input logic [NST-1:0] stage_sel,
    input logic           hi_gain,
    input logic           gcal_en,
    input logic           done,
    input logic           go,
    input logic [2:0]     fail_phase
);
    logic mono_seen, cal_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mono_seen <= 1'b0;
            cal_seen  <= 1'b0;
        end else if (mono_req) begin
            mono_seen <= 1'b1;
            cal_seen  <= 1'b0;
        end else if (cal_req && cal_ready) begin
            cal_seen <= 1'b1;
        end
    end

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({mono_req, gain_req, cal_req, dly_req})); // R9
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) (gain_req || dly_req) |-> $onehot(stage_sel)); // R2
    AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (gain_req && $past(gain_req)) |-> $stable(stage_sel)); // R2
    AST_GAIN_CAL_OFF: assert property (@(posedge clk) disable iff (!rst_n) gain_req |-> !gcal_en); // R3
    AST_GAIN_AFTER_MONO: assert property (@(posedge clk) disable iff (!rst_n) gain_req |-> mono_seen); // R1
    AST_DLY_AFTER_CAL: assert property (@(posedge clk) disable iff (!rst_n) dly_req |-> cal_seen); // R4
    AST_HI_GAIN_DLY: assert property (@(posedge clk) disable iff (!rst_n) hi_gain == dly_req); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
    AST_GO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) go |-> (fail_phase == 3'd0)); // R6

endmodule

bind adc_bist_seq adc_bist_seq_chk #(.NST(NST)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mono_req   (mono_req),
    .gain_req   (gain_req),
    .cal_req    (cal_req),
    .cal_ready  (cal_ready),
    .dly_req    (dly_req),
    .stage_sel  (stage_sel),
    .hi_gain    (hi_gain),
    .gcal_en    (gcal_en),
    .done       (done),
    .go         (go),
    .fail_phase (fail_phase)
);

// File: tb/adc_bist_seq_bench.sv
module adc_bist_seq_bench;
    localparam int NST = 4;
    localparam int TW  = 8;
    localparam int SW  = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [TW-1:0]  timeout_limit = 8'd20;
    logic           mono_req, gain_req, cal_req, dly_req;
    logic           mono_done = 1'b0, mono_pass = 1'b0;
    logic           gain_done = 1'b0, gain_pass = 1'b0;
    logic           cal_ready = 1'b0;
    logic           dly_done = 1'b0, dly_pass = 1'b0;
    logic [NST-1:0] stage_sel;
    logic           hi_gain, gcal_en, busy, done, go;
    logic [2:0]     fail_phase;
    logic [SW-1:0]  fail_stage;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    adc_bist_seq #(.NST(NST), .TW(TW)) u_adc_bist_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .timeout_limit(timeout_limit),
        .mono_req(mono_req), .mono_done(mono_done), .mono_pass(mono_pass),
        .gain_req(gain_req), .gain_done(gain_done), .gain_pass(gain_pass),
        .cal_req(cal_req), .cal_ready(cal_ready),
        .dly_req(dly_req), .dly_done(dly_done), .dly_pass(dly_pass),
        .stage_sel(stage_sel), .hi_gain(hi_gain), .gcal_en(gcal_en),
        .busy(busy), .done(done), .go(go),
        .fail_phase(fail_phase), .fail_stage(fail_stage)
    );

    // limit, mono fail, mono silent, gain fail stage, cal silent,
    // delay fail stage, delay silent stage, restart poke,
    // expected go, phase, stage, gain requests, delay requests (7 = none)
    typedef struct packed {
        logic [7:0] lim;
        logic       mbad;
        logic       mhang;
        logic [2:0] gbad;
        logic       chang;
        logic [2:0] dbad;
        logic [2:0] dhang;
        logic       poke;
        logic       xgo;
        logic [2:0] xph;
        logic [2:0] xst;
        logic [3:0] xg;
        logic [3:0] xd;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{8'd20, 1'b0, 1'b0, 3'd7, 1'b0, 3'd7, 3'd7, 1'b0, 1'b1, 3'd0, 3'd0, 4'd4, 4'd4},
        '{8'd20, 1'b1, 1'b0, 3'd7, 1'b0, 3'd7, 3'd7, 1'b0, 1'b0, 3'd1, 3'd0, 4'd0, 4'd0},
        '{8'd20, 1'b0, 1'b0, 3'd2, 1'b0, 3'd7, 3'd7, 1'b0, 1'b0, 3'd2, 3'd2, 4'd3, 4'd0},
        '{8'd20, 1'b0, 1'b0, 3'd7, 1'b0, 3'd3, 3'd7, 1'b0, 1'b0, 3'd4, 3'd3, 4'd4, 4'd4},
        '{8'd20, 1'b0, 1'b0, 3'd7, 1'b1, 3'd7, 3'd7, 1'b0, 1'b0, 3'd3, 3'd0, 4'd4, 4'd0},
        '{8'd20, 1'b0, 1'b0, 3'd0, 1'b0, 3'd7, 3'd7, 1'b0, 1'b0, 3'd2, 3'd0, 4'd1, 4'd0},
        '{8'd20, 1'b0, 1'b0, 3'd7, 1'b0, 3'd7, 3'd7, 1'b1, 1'b1, 3'd0, 3'd0, 4'd4, 4'd4},
        '{8'd12, 1'b0, 1'b0, 3'd7, 1'b0, 3'd7, 3'd1, 1'b0, 1'b0, 3'd4, 3'd1, 4'd4, 4'd2},
        '{8'd5,  1'b0, 1'b1, 3'd7, 1'b0, 3'd7, 3'd7, 1'b0, 1'b0, 3'd1, 3'd0, 4'd0, 4'd0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sel2idx(input logic [NST-1:0] s);
        int r = -1;
        if ($countones(s) == 1) begin
            for (int i = 0; i < NST; i++) if (s[i]) r = i;
        end
        return r;
    endfunction

    task automatic run_vec(input vec_t v);
        int  monos = 0, gains = 0, dlys = 0, mono_cyc = 0, dones = 0;
        bit  pm = 0, pg = 0, pd = 0, cal_seen = 0, poked = 0;
        bit  ord_ok = 1, sel_ok = 1, hg_ok = 1, gc_ok = 1, one_ok = 1;
        bit  finished = 0, start_seen = 0;
        int  cur = -1;
        timeout_limit = v.lim;
        @(negedge clk);
        start = 1'b1;
        for (int cyc = 0; cyc < 3000 && !finished; cyc++) begin
            @(negedge clk);
            start = 1'b0;
            cur = sel2idx(stage_sel);
            if (done) begin
                dones++;
                start_seen = 1;
            end else if (start_seen) begin
                finished = 1;
            end
            if ($countones({mono_req, gain_req, cal_req, dly_req}) > 1) one_ok = 0;
            if (mono_req) mono_cyc++;
            if (mono_req && !pm) monos++;
            if (gain_req && !pg) begin
                if (cur != gains) ord_ok = 0;
                gains++;
                if (v.poke && cur == 2 && !poked) begin
                    start = 1'b1;
                    poked = 1;
                end
            end
            if (gain_req && gcal_en) gc_ok = 0;
            if (!gain_req && !busy && !gcal_en) gc_ok = 0;
            if ((gain_req || dly_req) && cur < 0) sel_ok = 0;
            if (dly_req && !pd) begin
                if (cur != dlys || !cal_seen) ord_ok = 0;
                dlys++;
            end
            if (hi_gain != dly_req) hg_ok = 0;
            pm = mono_req;
            pg = gain_req;
            pd = dly_req;
            mono_done = mono_req && !v.mhang;
            mono_pass = !v.mbad;
            gain_done = gain_req;
            gain_pass = (cur != int'(v.gbad));
            cal_ready = cal_req && !v.chang;
            if (cal_req && !v.chang) cal_seen = 1;
            dly_done  = dly_req && (cur != int'(v.dhang));
            dly_pass  = (cur != int'(v.dbad));
        end
        chk(finished, "R8 run finished (watchdog)", finished, 1);
        chk(dones == 1, "R8 done width", dones, 1);
        chk(go == v.xgo, "R8 go", go, v.xgo);
        chk(fail_phase == v.xph, "R6 fail_phase", fail_phase, v.xph);
        chk(int'(fail_stage) == int'(v.xst), "R6 fail_stage", fail_stage, v.xst);
        chk(monos == 1, "R1 single monotonicity request (restart ignored)", monos, 1);
        chk(gains == int'(v.xg), "R2 gain request count", gains, v.xg);
        chk(dlys == int'(v.xd), "R5 delay request count", dlys, v.xd);
        chk(ord_ok, "R4 stage order and calibration gate", ord_ok, 1);
        chk(sel_ok, "R2 one-hot stage_sel", sel_ok, 1);
        chk(hg_ok, "R5 hi_gain tracks dly_req", hg_ok, 1);
        chk(gc_ok, "R3 gcal_en", gc_ok, 1);
        chk(one_ok, "R9 single request", one_ok, 1);
        if (v.mhang) chk(mono_cyc == int'(v.lim) + 1, "R7 timeout cycle", mono_cyc, int'(v.lim) + 1);
        mono_done = 0; gain_done = 0; cal_ready = 0; dly_done = 0;
        // R8 results hold while idle
        repeat (3) @(negedge clk);
        chk(go == v.xgo && fail_phase == v.xph, "R8 results held", fail_phase, v.xph);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({mono_req, gain_req, cal_req, dly_req, done, go, hi_gain} == 7'd0, "R1 reset outputs", 1, 0);
        chk(stage_sel == '0 && fail_phase == 3'd0 && gcal_en, "R1 reset selects", stage_sel, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 start in idle raises mono_req next cycle
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(mono_req == 1'b1, "R1 mono_req after start", mono_req, 1);
        mono_done = 1'b1; mono_pass = 1'b0;
        @(negedge clk);
        mono_done = 1'b0;
        chk(done == 1'b1 && fail_phase == 3'd1, "R6 immediate mono fail", fail_phase, 1);
        repeat (2) @(negedge clk);
        for (int k = 0; k < NV; k++) run_vec(VEC[k]);
        // R8 a new start clears sticky results
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(fail_phase == 3'd0 && go == 1'b0, "R8 start clears results", fail_phase, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule